// File: doc/BRIEF.md
# Bit-Serial Adder with J-K Carry State

This block adds two binary words one bit position per clock. On each cycle the caller presents one bit of each operand, lowest position first. The block returns the matching sum bit in the same cycle. The carry into the next position is a single state bit, so the block is a two-state Mealy machine: no-carry (carry bit 0) and carry (carry bit 1). The sum output depends on the present inputs and the present state.

The carry bit is updated through J-K excitation. The set input is driven high when both operand bits are 1, and the release input is driven high when both are 0. A parameter selects an equivalent toggle form, which flips the state only when the excitation disagrees with it. Both forms produce the same output sequence.

A synchronous clear input returns the carry to the no-carry state at the next clock edge so that a new word can start. The active-low asynchronous reset does the same thing at any time. Framing the words and shifting the operands in belong to the surrounding logic.

Top module: `serial_sum_unit`

## Requirements
- R1: While rst_ni is low, carry_o is 0 (no-carry state) in both carry forms.
- R2: sum_o equals a_i XOR b_i XOR carry_o in the same cycle. Bits 00 or 11 give sum_o = carry_o. Bits 01 or 10 give the inverse of carry_o.
- R3: In the no-carry state with clear_i low, the next state is carry only when a_i and b_i are both 1. Inputs 00, 01 and 10 leave carry_o at 0.
- R4: In the carry state with clear_i low, the next state is no-carry only when a_i and b_i are both 0. Inputs 01, 10 and 11 keep carry_o at 1.
- R5: clear_i high forces carry_o to 0 after the next rising edge, whatever the inputs and the prior state, including inputs 11. In that same cycle, sum_o still uses the old carry.
- R6: Operands are presented lowest bit first. Adding 01100 and 01110 over five cycles gives the sum bits 0,1,0,1,1 in that order, which is 11010, and leaves carry_o at 0.
- R7: FORM = CARRY_JK (J-K excitation) and FORM = CARRY_T (toggle excitation) give identical sum_o and carry_o sequences for the same stimulus.
- R8: For any two 8-bit words presented after a clear, the eight collected sum bits equal the low 8 bits of their integer sum. The carry_o value after the last bit equals bit 8 of that sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the carry |
| clear_i | input | 1 | Synchronous clear of the carry before a new word |
| a_i | input | 1 | Operand A bit for the current position |
| b_i | input | 1 | Operand B bit for the current position |
| sum_o | output | 1 | Sum bit for the current position |
| carry_o | output | 1 | Carry state (0 = no carry, 1 = carry) |

## Verification
Two functions can act in the same cycle: the synchronous clear, and the carry generation caused by both operand bits being 1. The bench drives clear_i together with inputs 11, once from the carry state and once from the no-carry state. It expects carry_o to read 0 after the edge. It also expects sum_o in that cycle to be formed from the carry value held before the clear. A reference model kept as integers judges every cycle. Every cycle also compares the J-K instance against the toggle instance.

// File: rtl/serial_sum_pkg.sv
package serial_sum_pkg;
  // Selects how the carry state bit is excited.
  typedef enum logic {
    CARRY_JK = 1'b0,
    CARRY_T  = 1'b1
  } carry_form_e;
endpackage

// File: rtl/carry_excite.sv
module carry_excite (
  input  logic a_i,
  input  logic b_i,
  output logic set_o,
  output logic rel_o
);
  // Generate when both bits are 1; release when both are 0.
  assign set_o = a_i & b_i;
  assign rel_o = ~a_i & ~b_i;
endmodule

// File: rtl/carry_flop.sv
module carry_flop
  import serial_sum_pkg::*;
#(
  parameter carry_form_e FORM = CARRY_JK
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  input  logic rel_i,
  output logic q_o
);
  logic q_q;
  logic q_next;

  generate
    if (FORM == CARRY_JK) begin : g_jk
      always_comb begin
        unique case ({set_i, rel_i})
          2'b10:   q_next = 1'b1;
          2'b01:   q_next = 1'b0;
          2'b11:   q_next = ~q_q;
          default: q_next = q_q;
        endcase
      end
    end else begin : g_t
      logic tog;
      // Toggle only when the excitation disagrees with the held state.
      assign tog    = (set_i & ~q_q) | (rel_i & q_q);
      assign q_next = q_q ^ tog;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (clear_i) q_q <= 1'b0;
    else              q_q <= q_next;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sum_bit.sv
module sum_bit (
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic sum_o
);
  assign sum_o = a_i ^ b_i ^ cin_i;
endmodule

// File: rtl/serial_sum_unit.sv
module serial_sum_unit
  import serial_sum_pkg::*;
#(
  parameter carry_form_e FORM = CARRY_JK
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic carry_o
);
  logic set_w;
  logic rel_w;
  logic carry_w;

  carry_excite u_excite (
    .a_i   (a_i),
    .b_i   (b_i),
    .set_o (set_w),
    .rel_o (rel_w)
  );

  carry_flop #(.FORM(FORM)) u_carry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .set_i   (set_w),
    .rel_i   (rel_w),
    .q_o     (carry_w)
  );

  sum_bit u_sum (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (carry_w),
    .sum_o (sum_o)
  );

  assign carry_o = carry_w;

  // R2
  sum_equal_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == b_i) |-> (sum_o == carry_w));
  // R2
  sum_odd_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != b_i) |-> (sum_o != carry_w));
  // R3
  carry_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_w && !clear_i) |=> (carry_w == $past(a_i & b_i)));
  // R4
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_w && !clear_i) |=> (carry_w == $past(a_i | b_i)));
  // R5
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !carry_w);
endmodule

// File: tb/tb_serial_sum_unit.sv
module tb_serial_sum_unit;
  import serial_sum_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic a = 1'b0;
  logic b = 1'b0;
  logic s_jk, c_jk, s_t, c_t;

  int checks = 0;
  int errors = 0;
  int ref_c = 0;

  always #5 clk = ~clk;

  serial_sum_unit #(.FORM(CARRY_JK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .a_i(a), .b_i(b),
    .sum_o(s_jk), .carry_o(c_jk));

  serial_sum_unit #(.FORM(CARRY_T)) dut_t (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .a_i(a), .b_i(b),
    .sum_o(s_t), .carry_o(c_t));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bit position: drive after falling edge, check sum before rising
  // edge, check carry after it. Returns the sum bit seen.
  task automatic step(input logic av, input logic bv, input logic cv,
                      input string req, output logic sbit);
    int tot;
    @(negedge clk);
    a = av; b = bv; clr = cv;
    #2;
    tot = int'(av) + int'(bv) + ref_c;
    check({req, "/R2 sum jk"}, int'(s_jk), tot % 2);
    check("R7 sum forms agree", int'(s_t), int'(s_jk));
    sbit = s_jk;
    ref_c = cv ? 0 : tot / 2;
    @(posedge clk);
    #1;
    check({req, " carry jk"}, int'(c_jk), ref_c);
    check("R7 carry forms agree", int'(c_t), int'(c_jk));
  endtask

  task automatic add_word(input int aw, input int bw, input int nb,
                          input string req);
    logic sb;
    int got;
    step(1'b0, 1'b0, 1'b1, "R5 clear before word", sb);
    got = 0;
    for (int i = 0; i < nb; i++) begin
      step(aw[i], bw[i], 1'b0, req, sb);
      got = got | (int'(sb) << i);
    end
    check({req, " word sum"}, got, (aw + bw) % (1 << nb));
    check({req, " carry out"}, int'(c_jk), ((aw + bw) >> nb) & 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic sb;
    a = 1'b1; b = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset holds carry at 0 even with generating inputs
    check("R1 reset carry jk", int'(c_jk), 0);
    check("R1 reset carry t", int'(c_t), 0);
    @(negedge clk);
    a = 1'b0; b = 1'b0;
    rst_n = 1'b1;
    ref_c = 0;

    // R3: from no-carry, only 11 generates
    step(1'b0, 1'b0, 1'b0, "R3 00", sb);
    step(1'b0, 1'b1, 1'b0, "R3 01", sb);
    step(1'b1, 1'b0, 1'b0, "R3 10", sb);
    step(1'b1, 1'b1, 1'b0, "R3 11", sb);
    // R4: from carry, only 00 releases
    step(1'b0, 1'b1, 1'b0, "R4 01", sb);
    step(1'b1, 1'b0, 1'b0, "R4 10", sb);
    step(1'b1, 1'b1, 1'b0, "R4 11", sb);
    step(1'b0, 1'b0, 1'b0, "R4 00", sb);

    // R5: clear collides with generation, from both states
    step(1'b1, 1'b1, 1'b0, "R5 setup", sb);
    step(1'b1, 1'b1, 1'b1, "R5 clear over 11 from carry", sb);
    step(1'b1, 1'b1, 1'b1, "R5 clear over 11 from no-carry", sb);
    step(1'b0, 1'b1, 1'b0, "R5 after clear", sb);

    // R6: 12 + 14 over five positions gives 26
    add_word(12, 14, 5, "R6");

    // R8: random words plus edge values
    add_word(255, 1, 8, "R8 wrap");
    add_word(255, 255, 8, "R8 max");
    add_word(0, 0, 8, "R8 zero");
    for (int w = 0; w < 200; w++)
      add_word(int'($urandom_range(255)), int'($urandom_range(255)), 8, "R8 random");

    // R1 again: asynchronous reset drops a live carry
    step(1'b1, 1'b1, 1'b0, "R1 setup", sb);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset jk", int'(c_jk), 0);
    check("R1 async reset t", int'(c_t), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule